// File: doc/BRIEF.md
# Single-Wire Bus Master Timing Engine

This block is the master side of an open-drain, half-duplex, single-wire bus. It drives an active-low pull-down enable and watches the wire level through a two-stage synchronizer. A host starts one of three operations: a bus reset with a presence check, a byte write, or a byte read. The block then produces the required low pulses and sample points. It returns a presence flag after a reset and the assembled byte after a read. Bits travel least significant first.

All timing is counted in ticks. A tick is a fixed number of clock cycles, set by a parameter. Every pulse width, sample point and slot length is also a parameter, counted in ticks. The same engine therefore runs the nominal 16 kbps timing (one tick per microsecond) or a far slower rate for heavily capacitive links. A single-cycle `done` pulse marks completion. Requests that arrive while an operation is running are dropped.

Top module: `swire_master`

## Requirements
- R1: A reset operation (cmdOp 2'b00) pulls the wire low for exactly RST_LOW_T ticks, starting the cycle after acceptance, and then releases it.
- R2: During a reset, the wire is sampled RST_SAMPLE_T ticks after release. `presence` becomes 1 if the wire was low at that point and 0 otherwise. The whole operation lasts RST_LOW_T + RST_REL_T ticks.
- R3: A write operation (cmdOp 2'b01) sends cmdData as 8 slots, bit 0 first. Each slot starts with a falling edge. The wire stays low W0_LOW_T ticks for a 0 bit and W1_LOW_T ticks for a 1 bit. A new slot begins every SLOT_T ticks.
- R4: A read operation (cmdOp 2'b10) runs 8 slots. In each slot the wire is pulled low for RD_LOW_T ticks. The wire is sampled RD_SAMPLE_T ticks after the falling edge. A low level reads as 0. The first bit sampled lands in rdData bit 0.
- R5: Every slot releases the wire at least one tick before the next falling edge.
- R6: One tick equals TICK_DIV clock cycles, so each duration above is its tick count times TICK_DIV cycles.
- R7: `busy` rises the cycle after a request is accepted. `done` pulses high for one cycle on the same edge where `busy` falls. That edge comes exactly the operation's tick total times TICK_DIV cycles after acceptance.
- R8: A request made while `busy` is high is ignored. It neither disturbs the running operation nor starts another afterwards.
- R9: Op code 2'b11 is ignored. It raises no `busy` and drives no pulse.
- R10: After reset, busDriveN is 1, and busy, done, presence and rdData are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Request strobe, taken only when idle |
| cmdOp | input | 2 | 00 reset, 01 write byte, 10 read byte, 11 none |
| cmdData | input | 8 | Byte to write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| presence | output | 1 | Result of the last reset's presence sample |
| rdData | output | 8 | Byte assembled by the last read |
| busDriveN | output | 1 | Pull-down enable, low means drive the wire low |
| busIn | input | 1 | Sensed wire level |

## Verification
The write path is swept over all 256 byte values. The measured low-pulse widths are decoded back into a byte, which separates a bit-order fault from a swapped 0/1 width and from a wrong slot period. The read path is swept over all 256 values returned by a modelled slave, which exposes a wrong sample point or a wrong fill direction of the shift register. Resets run with and without a responding slave, so a stuck presence flag is caught. Requests made during a running write, and the unused op code, show whether the engine accepts anything outside the idle state.

// File: rtl/swire_pkg.sv
package swire_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_NONE  = 2'b11
  } opE;

  typedef struct packed {
    logic loadTx;
    logic setLow;
    logic clrLow;
    logic sampleRx;
    logic shiftTx;
    logic samplePres;
  } strobeT;

endpackage

// File: rtl/swire_ctrl.sv
module swire_ctrl
  import swire_pkg::*;
#(
  parameter int TICK_DIV     = 50,
  parameter int BYTE_W       = 8,
  parameter int RST_LOW_T    = 480,
  parameter int RST_SAMPLE_T = 70,
  parameter int RST_REL_T    = 480,
  parameter int SLOT_T       = 65,
  parameter int W0_LOW_T     = 60,
  parameter int W1_LOW_T     = 6,
  parameter int RD_LOW_T     = 1,
  parameter int RD_SAMPLE_T  = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       txBit,
  output strobeT     stb,
  output logic       busy,
  output logic       done
);

  localparam int MAX_A = (RST_LOW_T > RST_REL_T) ? RST_LOW_T : RST_REL_T;
  localparam int MAX_T = (MAX_A > SLOT_T) ? MAX_A : SLOT_T;
  localparam int CNT_W = $clog2(MAX_T + 1);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int BIT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

  typedef enum logic [1:0] {S_IDLE, S_RLOW, S_RHIGH, S_SLOT} stateE;

  stateE            state;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] tickCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             isRead;

  logic             tick;
  logic             accept;
  logic [CNT_W-1:0] lowEnd;
  logic             slotEnd;
  logic             lastBit;

  assign tick    = (divCnt == DIV_W'(TICK_DIV - 1));
  assign accept  = (state == S_IDLE) && cmdValid && (opE'(cmdOp) != OP_NONE);
  assign lowEnd  = isRead ? CNT_W'(RD_LOW_T) : (txBit ? CNT_W'(W1_LOW_T) : CNT_W'(W0_LOW_T));
  assign slotEnd = (state == S_SLOT) && tick && (tickCnt == CNT_W'(SLOT_T - 1));
  assign lastBit = (bitCnt == BIT_W'(BYTE_W - 1));
  assign busy    = (state != S_IDLE);

  always_comb begin
    stb            = '0;
    stb.loadTx     = accept && (opE'(cmdOp) == OP_WRITE);
    stb.setLow     = accept || (slotEnd && !lastBit);
    stb.clrLow     = tick && (((state == S_RLOW) && (tickCnt == CNT_W'(RST_LOW_T - 1))) ||
                              ((state == S_SLOT) && (tickCnt == lowEnd - CNT_W'(1))));
    stb.samplePres = (state == S_RHIGH) && tick && (tickCnt == CNT_W'(RST_SAMPLE_T - 1));
    stb.sampleRx   = (state == S_SLOT) && isRead && tick && (tickCnt == CNT_W'(RD_SAMPLE_T - 1));
    stb.shiftTx    = slotEnd && !isRead;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      divCnt  <= '0;
      tickCnt <= '0;
      bitCnt  <= '0;
      isRead  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == S_IDLE) begin
        if (accept) begin
          divCnt  <= '0;
          tickCnt <= '0;
          bitCnt  <= '0;
          isRead  <= (opE'(cmdOp) == OP_READ);
          state   <= (opE'(cmdOp) == OP_RESET) ? S_RLOW : S_SLOT;
        end
      end else begin
        divCnt <= tick ? '0 : divCnt + DIV_W'(1);
        if (tick) begin
          tickCnt <= tickCnt + CNT_W'(1);
          unique case (state)
            S_RLOW: if (tickCnt == CNT_W'(RST_LOW_T - 1)) begin
              tickCnt <= '0;
              state   <= S_RHIGH;
            end
            S_RHIGH: if (tickCnt == CNT_W'(RST_REL_T - 1)) begin
              tickCnt <= '0;
              state   <= S_IDLE;
              done    <= 1'b1;
            end
            S_SLOT: if (tickCnt == CNT_W'(SLOT_T - 1)) begin
              tickCnt <= '0;
              if (lastBit) begin
                state <= S_IDLE;
                done  <= 1'b1;
              end else begin
                bitCnt <= bitCnt + BIT_W'(1);
              end
            end
            default: state <= S_IDLE;
          endcase
        end
      end
    end
  end

  // R7: completion is only signalled once the engine is idle again
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R3: the slot counter never runs past its period or the byte length
  a_r3_slot_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SLOT) |-> (tickCnt < CNT_W'(SLOT_T)) && (int'(bitCnt) < BYTE_W));

  // R8: a busy engine stays busy or finishes, never re-accepts
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdValid) |=> (busy || done));

endmodule

// File: rtl/swire_dp.sv
module swire_dp
  import swire_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [BYTE_W-1:0] txData,
  input  logic              busIn,
  output logic              pullDn,
  output logic              txBit,
  output logic [BYTE_W-1:0] rdData,
  output logic              presence
);

  logic [SYNC_N-1:0] syncQ;
  logic              busSync;
  logic [BYTE_W-1:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_N-2:0], busIn};
  end
  assign busSync = syncQ[SYNC_N-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pullDn   <= 1'b0;
      shReg    <= '0;
      presence <= 1'b0;
    end else begin
      if (stb.setLow)      pullDn <= 1'b1;
      else if (stb.clrLow) pullDn <= 1'b0;

      if (stb.loadTx)        shReg <= txData;
      else if (stb.sampleRx) shReg <= {busSync, shReg[BYTE_W-1:1]};
      else if (stb.shiftTx)  shReg <= {1'b0, shReg[BYTE_W-1:1]};

      if (stb.samplePres) presence <= ~busSync;
    end
  end

  assign txBit  = shReg[0];
  assign rdData = shReg;

  // R4: a read bit is taken only while the master has let go of the wire
  a_r4_sample_released: assert property (@(posedge clk) disable iff (!rstN)
    stb.sampleRx |-> !pullDn);

  // R2: the presence sample is taken with the wire released
  a_r2_pres_released: assert property (@(posedge clk) disable iff (!rstN)
    stb.samplePres |-> !pullDn);

  // R5: the wire is released when a write slot closes
  a_r5_recovery: assert property (@(posedge clk) disable iff (!rstN)
    stb.shiftTx |-> !pullDn);

endmodule

// File: rtl/swire_master.sv
module swire_master
  import swire_pkg::*;
#(
  parameter int TICK_DIV     = 50,
  parameter int RST_LOW_T    = 480,
  parameter int RST_SAMPLE_T = 70,
  parameter int RST_REL_T    = 480,
  parameter int SLOT_T       = 65,
  parameter int W0_LOW_T     = 60,
  parameter int W1_LOW_T     = 6,
  parameter int RD_LOW_T     = 1,
  parameter int RD_SAMPLE_T  = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic [7:0] cmdData,
  output logic       busy,
  output logic       done,
  output logic       presence,
  output logic [7:0] rdData,
  output logic       busDriveN,
  input  logic       busIn
);

  localparam int BYTE_W = 8;

  strobeT stb;
  logic   txBit;
  logic   pullDn;

  swire_ctrl #(
    .TICK_DIV(TICK_DIV), .BYTE_W(BYTE_W),
    .RST_LOW_T(RST_LOW_T), .RST_SAMPLE_T(RST_SAMPLE_T), .RST_REL_T(RST_REL_T),
    .SLOT_T(SLOT_T), .W0_LOW_T(W0_LOW_T), .W1_LOW_T(W1_LOW_T),
    .RD_LOW_T(RD_LOW_T), .RD_SAMPLE_T(RD_SAMPLE_T)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .txBit(txBit), .stb(stb), .busy(busy), .done(done)
  );

  swire_dp #(.BYTE_W(BYTE_W), .SYNC_N(2)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .txData(cmdData), .busIn(busIn),
    .pullDn(pullDn), .txBit(txBit), .rdData(rdData), .presence(presence)
  );

  assign busDriveN = ~pullDn;

  // R1: the wire is only ever driven while an operation runs
  a_r1_drive_busy: assert property (@(posedge clk) disable iff (!rstN)
    !busDriveN |-> busy);

endmodule

// File: tb/swire_master_bench.sv
module swire_master_bench;

  localparam int D    = 2;
  localparam int RLOW = 12;
  localparam int RSMP = 4;
  localparam int RREL = 12;
  localparam int SLOT = 10;
  localparam int W0   = 8;
  localparam int W1   = 2;
  localparam int RDL  = 1;
  localparam int RDS  = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'b11;
  logic [7:0] cmdData = 8'h00;
  logic       busy, done, presence, busDriveN, busIn;
  logic [7:0] rdData;
  logic       slaveLow = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  int slaveMode = 0;
  logic [7:0] slaveByte = 8'h00;
  int rdIdx = 0;

  int nLow = 0;
  int runLen = 0;
  logic prevN = 1'b1;
  int lowLen [16];
  int fallCyc [16];

  always #5 clk = ~clk;

  assign busIn = busDriveN & ~slaveLow;

  swire_master #(
    .TICK_DIV(D), .RST_LOW_T(RLOW), .RST_SAMPLE_T(RSMP), .RST_REL_T(RREL),
    .SLOT_T(SLOT), .W0_LOW_T(W0), .W1_LOW_T(W1), .RD_LOW_T(RDL), .RD_SAMPLE_T(RDS)
  ) u_swire_master (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdData(cmdData),
    .busy(busy), .done(done), .presence(presence), .rdData(rdData),
    .busDriveN(busDriveN), .busIn(busIn)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!busDriveN && prevN) begin
      if (nLow < 16) fallCyc[nLow] = cyc;
      runLen = 1;
    end else if (!busDriveN) begin
      runLen = runLen + 1;
    end
    if (busDriveN && !prevN) begin
      if (nLow < 16) lowLen[nLow] = runLen;
      nLow = nLow + 1;
    end
    prevN = busDriveN;
  end

  // slave answering read slots
  initial forever begin
    @(negedge busDriveN);
    if (slaveMode == 2) begin
      logic b;
      b = slaveByte[rdIdx % 8];
      rdIdx = rdIdx + 1;
      if (!b) begin
        @(negedge clk) slaveLow = 1'b1;
        repeat (6 * D) @(negedge clk);
        slaveLow = 1'b0;
      end
    end
  end

  // slave answering a reset with a presence pulse
  initial forever begin
    @(posedge busDriveN);
    if (slaveMode == 1) begin
      repeat (2 * D) @(negedge clk);
      slaveLow = 1'b1;
      repeat (6 * D) @(negedge clk);
      slaveLow = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic startCmd(input logic [1:0] op, input logic [7:0] data, output int t0);
    @(negedge clk);
    nLow = 0;
    cmdValid = 1'b1;
    cmdOp = op;
    cmdData = data;
    @(negedge clk);
    cmdValid = 1'b0;
    cmdOp = 2'b11;
    t0 = cyc;
  endtask

  task automatic waitDone(input int t0, output int elapsed);
    int guard;
    guard = 0;
    while (!done && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    elapsed = cyc - t0;
  endtask

  function automatic int decodeWrite();
    int v;
    v = 0;
    for (int i = 0; i < 8; i++) begin
      if (lowLen[i] == W1 * D) v |= (1 << i);
      else if (lowLen[i] != W0 * D) v |= 1 << 9;
    end
    return v;
  endfunction

  function automatic bit slotsSpaced();
    bit ok;
    ok = 1'b1;
    for (int i = 0; i < 7; i++) begin
      if (fallCyc[i + 1] - fallCyc[i] != SLOT * D) ok = 1'b0;
      if (SLOT * D - lowLen[i] < D) ok = 1'b0;
    end
    return ok;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t0, el;
    int pat, prevLow;
    bit sawBusy;

    repeat (3) @(negedge clk);
    // R10: reset state
    check(busDriveN === 1'b1 && busy === 1'b0 && done === 1'b0 && presence === 1'b0
          && rdData === 8'h00, "R10 reset state", int'(busDriveN), 1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 R6 R7: reset with a slave present
    slaveMode = 1;
    startCmd(2'b00, 8'h00, t0);
    check(busy === 1'b1, "R7 busy after accept", int'(busy), 1);
    waitDone(t0, el);
    check(el == (RLOW + RREL) * D, "R2 reset duration", el, (RLOW + RREL) * D);
    check(nLow == 1 && lowLen[0] == RLOW * D, "R1 R6 reset low width", lowLen[0], RLOW * D);
    check(presence === 1'b1, "R2 presence seen", int'(presence), 1);
    check(busy === 1'b0, "R7 busy falls with done", int'(busy), 0);
    @(negedge clk);
    check(done === 1'b0, "R7 done one cycle", int'(done), 0);

    // R2: reset with no slave
    slaveMode = 0;
    startCmd(2'b00, 8'h00, t0);
    waitDone(t0, el);
    check(presence === 1'b0, "R2 presence absent", int'(presence), 0);

    // R2: presence again
    slaveMode = 1;
    startCmd(2'b00, 8'h00, t0);
    waitDone(t0, el);
    check(presence === 1'b1, "R2 presence back", int'(presence), 1);
    slaveMode = 0;

    // R3 R5 R7: all write values
    for (int b = 0; b < 256; b++) begin
      startCmd(2'b01, 8'(b), t0);
      waitDone(t0, el);
      @(negedge clk);
      pat = decodeWrite();
      check(nLow == 8 && pat == b, "R3 write pattern", pat, b);
      check(slotsSpaced(), "R5 slot spacing and gap", fallCyc[1] - fallCyc[0], SLOT * D);
      if (b % 64 == 0)
        check(el == 8 * SLOT * D, "R7 write duration", el, 8 * SLOT * D);
    end

    // R4: all read values
    for (int b = 0; b < 256; b++) begin
      slaveByte = 8'(b);
      rdIdx = 0;
      slaveMode = 2;
      startCmd(2'b10, 8'h00, t0);
      waitDone(t0, el);
      slaveMode = 0;
      @(negedge clk);
      check(rdData == 8'(b), "R4 read data", int'(rdData), b);
      check(nLow == 8 && lowLen[0] == RDL * D && lowLen[7] == RDL * D,
            "R4 read pulse width", lowLen[0], RDL * D);
      if (b % 64 == 0)
        check(el == 8 * SLOT * D, "R7 read duration", el, 8 * SLOT * D);
    end

    // R8: request during a running write is dropped
    startCmd(2'b01, 8'h5A, t0);
    repeat (30) @(negedge clk);
    cmdValid = 1'b1;
    cmdOp = 2'b00;
    @(negedge clk);
    cmdValid = 1'b0;
    cmdOp = 2'b11;
    waitDone(t0, el);
    @(negedge clk);
    pat = decodeWrite();
    check(nLow == 8 && pat == 8'h5A, "R8 write undisturbed", pat, 8'h5A);
    check(el == 8 * SLOT * D, "R8 duration unchanged", el, 8 * SLOT * D);
    prevLow = nLow;
    sawBusy = 1'b0;
    repeat (40) begin
      @(negedge clk);
      if (busy) sawBusy = 1'b1;
    end
    check(!sawBusy && nLow == prevLow, "R8 nothing started later", int'(sawBusy), 0);

    // R9: op code 11 ignored
    startCmd(2'b11, 8'hFF, t0);
    sawBusy = 1'b0;
    repeat (30) begin
      if (busy) sawBusy = 1'b1;
      @(negedge clk);
    end
    check(!sawBusy && nLow == 0, "R9 unused op ignored", nLow, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule